// File: doc/BRIEF.md
# Radio Status and Command-End Interrupt Controller

This block sits between the tuner's status logic and the host interrupt line. It holds two latched event flags. The radio flag latches when the 3-bit signal-level reading or the stereo indication changes. The command flag latches when a tune or seek command reports completion. Each flag is cleared by a read of its own status register. A set event that arrives in the same cycle as a clearing read wins, so no event is lost.

The host interrupt output is the OR of the flags whose enable bit is set. It is inverted when the polarity bit selects active-low, and it comes from a flop, so it cannot glitch. While the radio power bit is low, the output enable is dropped so the pin floats. The radio flag is held clear internally and reads back as 1. The block also assembles the radio status byte that the register file returns for the status address.

Top module: `irq_status_ctrl`

## Requirements
- R1: When radio power is on, a change of `fs_lvl` from one cycle to the next sets `radio_flag` at the following clock edge.
- R2: When radio power is on, a change of `stereo_ind` from one cycle to the next sets `radio_flag` at the following clock edge.
- R3: `rd_stat` high at a clock edge clears the radio flag. If a level or stereo change is detected at that same edge, the flag stays set.
- R4: While `pwr_on` is 0, `radio_flag` reads 1, level and stereo changes are ignored, and the internal radio flag is cleared. After power returns, the flag reads 0 until a new change occurs.
- R5: `cmd_done` high at a clock edge sets `cmd_flag`. `rd_tune` high at an edge clears it. When both are high, the flag stays set.
- R6: `rd_stat` does not affect `cmd_flag`, and `rd_tune` does not affect the radio flag.
- R7: `irq_o` is a registered copy of (enabled radio flag OR enabled command flag). It is inverted when `irq_pol_low` is 1, and it lags the flags by one clock.
- R8: A flag whose enable (`radio_ie` or `cmd_ie`) is 0 does not drive `irq_o` to its active level.
- R9: `irq_oe` equals `pwr_on` as sampled at the previous clock edge, so the pin is undriven while power is off.
- R10: `stat_byte` bit positions are: bit 7 = `radio_flag`, bits 6:5 = 0, bit 4 = `stereo_ind`, bits 3:1 = `fs_lvl`, bit 0 = `fs_plus5`.
- R11: During reset, both flags are 0, `irq_o` is 0 and `irq_oe` is 0.
- R12: The first clock edge after reset only captures the baseline level and stereo values. It never sets the radio flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Radio power bit |
| irq_pol_low | input | 1 | 1 selects an active-low interrupt |
| radio_ie | input | 1 | Enables the radio flag onto the pin |
| cmd_ie | input | 1 | Enables the command flag onto the pin |
| fs_lvl | input | 3 | Signal-level reading |
| stereo_ind | input | 1 | Stereo indication |
| fs_plus5 | input | 1 | +5 dB level indication |
| cmd_done | input | 1 | Command completion pulse |
| rd_stat | input | 1 | Read strobe for the radio status register |
| rd_tune | input | 1 | Read strobe for the tune status register |
| radio_flag | output | 1 | Radio flag as read back |
| cmd_flag | output | 1 | Command-end flag |
| stat_byte | output | 8 | Assembled radio status byte |
| irq_o | output | 1 | Interrupt pin data |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The hardest case to reach is a clearing read that lands in the same cycle as a new set event. The stimulus builds it deliberately for both flags. It raises `rd_stat` in the cycle where `fs_lvl` steps to a new value, and it raises `rd_tune` together with `cmd_done`. A second hard case is the power-down window. While power is off, the level input is moved, and then power comes back with the level unchanged. This shows that the changes made while powered down leave no latched event behind.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int FS_W     = 3;
  localparam int NUM_SRC  = 2;
  localparam int SRC_RAD  = 0;
  localparam int SRC_CMD  = 1;
  localparam int STAT_W   = 8;

  // status byte: flag, two zero bits, stereo, level, +5 dB
  function automatic logic [STAT_W-1:0] stat_pack(
    input logic flag, input logic st, input logic [FS_W-1:0] fs, input logic p5);
    return {flag, 2'b00, st, fs, p5};
  endfunction

  // level presented on the pin for a given flag/enable/polarity set
  function automatic logic pin_level(
    input logic [NUM_SRC-1:0] flags, input logic [NUM_SRC-1:0] en, input logic pol_low);
    return (|(flags & en)) ^ pol_low;
  endfunction
endpackage

// File: rtl/irq_change_det.sv
module irq_change_det #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr,
  input  logic [W-1:0] lvl,
  input  logic         st,
  output logic         evt,
  output logic         seen
);
  logic [W-1:0] lvl_q;
  logic         st_q;
  logic         seen_q;
  logic         differs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      st_q   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      lvl_q  <= lvl;
      st_q   <= st;
      seen_q <= 1'b1;
    end
  end

  always_comb begin
    differs = (lvl != lvl_q) || (st != st_q);
    evt     = pwr && seen_q && differs;
  end

  assign seen = seen_q;

  // R12
  first_edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !evt);
endmodule

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic hold_off,
  output logic q
);
  logic q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q_r <= 1'b0;
    else if (hold_off) q_r <= 1'b0;
    else if (set_i)    q_r <= 1'b1;
    else if (clr_i)    q_r <= 1'b0;
  end

  assign q = q_r;

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !hold_off) |=> q_r);
  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_r);
  // R6
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_r && !clr_i && !hold_off) |=> q_r);
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv
  import irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] en,
  input  logic         pol_low,
  input  logic         pwr,
  output logic         irq_o,
  output logic         irq_oe
);
  logic pin_q;
  logic oe_q;
  logic any_live;

  assign any_live = |(flags & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      pin_q <= pin_level(flags, en, pol_low);
      oe_q  <= pwr;
    end
  end

  assign irq_o  = pin_q;
  assign irq_oe = oe_q;

  // R7
  pin_active_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_live && !pol_low) |=> irq_o);
  // R7
  pin_active_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_live && pol_low) |=> !irq_o);
  // R8
  pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_live) |=> (irq_o == $past(pol_low)));
  // R9
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr |=> irq_oe);
  // R9
  oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr |=> !irq_oe);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int LVL_W = FS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on,
  input  logic             irq_pol_low,
  input  logic             radio_ie,
  input  logic             cmd_ie,
  input  logic [LVL_W-1:0] fs_lvl,
  input  logic             stereo_ind,
  input  logic             fs_plus5,
  input  logic             cmd_done,
  input  logic             rd_stat,
  input  logic             rd_tune,
  output logic             radio_flag,
  output logic             cmd_flag,
  output logic [7:0]       stat_byte,
  output logic             irq_o,
  output logic             irq_oe
);
  logic                 radio_evt_w;
  logic                 seen_w;
  logic [NUM_SRC-1:0]   set_vec;
  logic [NUM_SRC-1:0]   clr_vec;
  logic [NUM_SRC-1:0]   off_vec;
  logic [NUM_SRC-1:0]   flag_vec;
  logic [NUM_SRC-1:0]   en_vec;

  irq_change_det #(.W(LVL_W)) u_det (
    .clk  (clk),
    .rst_n(rst_n),
    .pwr  (pwr_on),
    .lvl  (fs_lvl),
    .st   (stereo_ind),
    .evt  (radio_evt_w),
    .seen (seen_w)
  );

  always_comb begin
    set_vec          = '0;
    clr_vec          = '0;
    off_vec          = '0;
    en_vec           = '0;
    set_vec[SRC_RAD] = radio_evt_w;
    clr_vec[SRC_RAD] = rd_stat;
    off_vec[SRC_RAD] = !pwr_on;
    en_vec[SRC_RAD]  = radio_ie;
    set_vec[SRC_CMD] = cmd_done;
    clr_vec[SRC_CMD] = rd_tune;
    en_vec[SRC_CMD]  = cmd_ie;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    irq_sticky_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_vec[g]),
      .clr_i   (clr_vec[g]),
      .hold_off(off_vec[g]),
      .q       (flag_vec[g])
    );
  end

  irq_pin_drv #(.N(NUM_SRC)) u_pin (
    .clk    (clk),
    .rst_n  (rst_n),
    .flags  (flag_vec),
    .en     (en_vec),
    .pol_low(irq_pol_low),
    .pwr    (pwr_on),
    .irq_o  (irq_o),
    .irq_oe (irq_oe)
  );

  assign radio_flag = flag_vec[SRC_RAD] | !pwr_on;
  assign cmd_flag   = flag_vec[SRC_CMD];
  assign stat_byte  = stat_pack(radio_flag, stereo_ind, fs_lvl, fs_plus5);

  // R1
  lvl_change_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_w && pwr_on && fs_lvl != $past(fs_lvl)) |=> flag_vec[SRC_RAD]);
  // R2
  st_change_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_w && pwr_on && stereo_ind != $past(stereo_ind)) |=> flag_vec[SRC_RAD]);
  // R4
  off_reads_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> radio_flag);
  // R4
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> !flag_vec[SRC_RAD]);
endmodule

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
  typedef struct {
    string      tag;
    logic       rflag;
    logic       cflag;
    logic [7:0] stat;
    logic       irq;
    logic       oe;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic pwr_on = 0, irq_pol_low = 0, radio_ie = 0, cmd_ie = 0;
  logic [2:0] fs_lvl = 0;
  logic stereo_ind = 0, fs_plus5 = 0, cmd_done = 0, rd_stat = 0, rd_tune = 0;
  logic radio_flag, cmd_flag, irq_o, irq_oe;
  logic [7:0] stat_byte;

  int checks = 0, errors = 0;
  bit finished = 0;
  exp_t q[$];

  // reference state
  logic m_r = 0, m_c = 0, m_seen = 0, m_irq = 0, m_oe = 0, m_st = 0;
  logic [2:0] m_fs = 0;

  always #10 clk = ~clk;

  irq_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .irq_pol_low(irq_pol_low),
    .radio_ie(radio_ie), .cmd_ie(cmd_ie), .fs_lvl(fs_lvl), .stereo_ind(stereo_ind),
    .fs_plus5(fs_plus5), .cmd_done(cmd_done), .rd_stat(rd_stat), .rd_tune(rd_tune),
    .radio_flag(radio_flag), .cmd_flag(cmd_flag), .stat_byte(stat_byte),
    .irq_o(irq_o), .irq_oe(irq_oe));

  task automatic compare(exp_t e);
    checks++;
    if (radio_flag !== e.rflag || cmd_flag !== e.cflag || stat_byte !== e.stat ||
        irq_o !== e.irq || irq_oe !== e.oe) begin
      errors++;
      $display("FAIL %s: got rf=%b cf=%b stat=%h irq=%b oe=%b exp rf=%b cf=%b stat=%h irq=%b oe=%b",
        e.tag, radio_flag, cmd_flag, stat_byte, irq_o, irq_oe,
        e.rflag, e.cflag, e.stat, e.irq, e.oe);
    end
  endtask

  // driver: inputs already set at a falling edge; model the next rising edge
  task automatic step(string tag);
    exp_t e;
    logic evt, nr, nc, rf;
    evt = pwr_on && m_seen && ((fs_lvl != m_fs) || (stereo_ind != m_st));
    nr  = !pwr_on ? 1'b0 : (evt ? 1'b1 : (rd_stat ? 1'b0 : m_r));
    nc  = cmd_done ? 1'b1 : (rd_tune ? 1'b0 : m_c);
    m_irq = ((m_r & radio_ie) | (m_c & cmd_ie)) ^ irq_pol_low;
    m_oe  = pwr_on;
    m_r = nr; m_c = nc; m_fs = fs_lvl; m_st = stereo_ind; m_seen = 1'b1;
    rf = m_r | !pwr_on;
    e.tag = tag; e.rflag = rf; e.cflag = m_c; e.irq = m_irq; e.oe = m_oe;
    e.stat = {rf, 2'b00, stereo_ind, fs_lvl, fs_plus5};
    q.push_back(e);
    @(negedge clk);
    cmd_done = 0; rd_stat = 0; rd_tune = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t r;
    repeat (2) @(negedge clk);
    // R11 reset state
    r.tag = "R11 reset"; r.rflag = 1'b1; r.cflag = 0; r.irq = 0; r.oe = 0;
    r.stat = 8'h80; compare(r);
    rst_n = 1;
    pwr_on = 1; radio_ie = 1; cmd_ie = 1; fs_lvl = 3'd3; stereo_ind = 1; fs_plus5 = 1;
    step("R12 baseline capture");
    step("R12 idle");
    fs_lvl = 3'd5; step("R1 level change");
    step("R7 pin high");
    rd_stat = 1; step("R3 read clears");
    step("R7 pin low");
    stereo_ind = 0; step("R2 stereo change");
    rd_stat = 1; fs_lvl = 3'd6; step("R3 read and change same edge");
    rd_stat = 1; step("R3 read clears after");
    fs_plus5 = 0; step("R10 plus5 no event");
    cmd_done = 1; step("R5 done sets");
    rd_stat = 1; step("R6 stat read leaves cmd");
    step("R7 pin from cmd");
    rd_tune = 1; cmd_done = 1; step("R5 done and read same edge");
    rd_tune = 1; step("R5 read clears");
    cmd_done = 1; step("R5 set again");
    cmd_ie = 0; step("R8 cmd masked");
    step("R8 pin idle");
    fs_lvl = 3'd1; rd_tune = 1; step("R6 tune read leaves radio");
    radio_ie = 0; step("R8 radio masked");
    step("R8 both masked pin idle");
    irq_pol_low = 1; radio_ie = 1; step("R7 active low set");
    step("R7 active low asserted");
    rd_stat = 1; step("R3 clear");
    step("R7 active low idle");
    pwr_on = 0; step("R4 power off");
    fs_lvl = 3'd7; stereo_ind = 1; step("R4 ignored while off");
    step("R9 oe low");
    pwr_on = 1; step("R4 power back");
    step("R9 oe high");
    fs_lvl = 3'd2; fs_plus5 = 1; step("R1 after power");
    step("R10 layout");
    @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule